// File: doc/BRIEF.md
# Control-Channel Loopback Reflection Controller

This block decides when the incoming serial control channel of a multi-channel voice processor is mirrored back onto the outgoing control channel. Each channel has its own control byte, and a periodic special frame carries a loopback-request bit. Loopback can be under hardware control, which follows edges of that request bit, or under software control, which follows a configuration bit. With hardware control, a switch takes effect only at the next per-channel frame-start strobe, so a channel frame is never cut in two.

Alongside the loopback decision, the block issues write strobes for received bytes into an internal capture RAM. It raises a maskable loopback-change interrupt and a listen interrupt. It keeps a per-channel disable bit and a per-channel flexible control bit, and holds both frozen while loopback is active. It also drives an active-low output-enable for the outgoing control stream, which is asserted only for channels that the current tail-length mode processes. Serial framing and deserialisation are done elsewhere. Received bytes arrive here already parallel, tagged with a channel number and a special-frame flag.

Top module: `ccl_reflect_ctrl`

## Requirements
- R1: With `cfg_hw_en`=1 and `cfg_sf_mode`=1, a special frame whose request bit (bit 0 of the byte) is 1 while the previous special frame's bit was 0 arms activation. `loop_active` becomes 1 in the cycle after the next `ch_start` strobe. A strobe in the same cycle as that special frame does not count.
- R2: Under the same configuration, a 1-to-0 change of the request bit arms deactivation. `loop_active` becomes 0 in the cycle after the next `ch_start` strobe.
- R3: A special frame produces `ram_we`=1 with `ram_special`=1 in the following cycle, unless loopback is active or activation is pending. The frame that carries the 0-to-1 change is written. The frame that carries the 1-to-0 change is written, and so is every special frame after it.
- R4: `irq_req_chg` pulses for one cycle after a special frame that carries a request-bit change (hardware control), or after a cycle in which `cfg_sw_loop` differs from `loop_active` (software control). It never pulses while `cfg_chg_mask` is 1.
- R5: With `cfg_hw_en`=0, `loop_active` takes the value of `cfg_sw_loop` one cycle later, and request bits in special frames have no effect on it.
- R6: While `loop_active` is 1, `dis_bits` and `fx_bits` keep their values whatever control bytes arrive.
- R7: For a non-special byte received for channel c while loopback is inactive, `fx_bits[c]` becomes byte bit 2 if `cfg_fx_sel`=11, bit 1 if 10, bit 0 if 01, and 0 if 00.
- R8: For the same byte, `dis_bits[c]` becomes byte bit 4 when `cfg_dis_en`=1 and 0 when `cfg_dis_en`=0.
- R9: Outside loopback every non-special byte is written (`ram_we`=1, `ram_special`=0, `ram_wdata` = the byte) and `irq_listen` stays 0. During loopback a non-special byte is written and pulses `irq_listen` only when `cfg_listen`=1. Otherwise neither happens.
- R10: On each `ch_start`, `tx_oe_n` becomes 0 when `ch_idx` is below 32 (`cfg_long_tail`=0) or below 16 (`cfg_long_tail`=1), and 1 otherwise. It holds between strobes.
- R11: After reset `loop_active`, `ram_we`, both interrupts, `dis_bits` and `fx_bits` are 0 and `tx_oe_n` is 1. The remembered request bit is 0, so a first special frame carrying 1 counts as a 0-to-1 change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hw_en | input | 1 | 1: hardware loopback control; 0: software control |
| cfg_sf_mode | input | 1 | Special-frame mode enable |
| cfg_sw_loop | input | 1 | Software loopback request |
| cfg_listen | input | 1 | Capture data bytes during loopback |
| cfg_dis_en | input | 1 | Use byte bit 4 as channel disable |
| cfg_fx_sel | input | 2 | Flexible control bit select |
| cfg_long_tail | input | 1 | 1: 16 processed channels; 0: 32 |
| cfg_chg_mask | input | 1 | Masks the loopback-change interrupt |
| ch_start | input | 1 | Per-channel frame-start strobe |
| ch_idx | input | 5 | Channel whose frame starts |
| rx_valid | input | 1 | Received control byte valid |
| rx_special | input | 1 | Byte belongs to a special frame |
| rx_chan | input | 5 | Channel of the received byte |
| rx_byte | input | 8 | Received control byte |
| ram_we | output | 1 | Capture RAM write strobe |
| ram_wdata | output | 8 | Capture RAM write data |
| ram_special | output | 1 | Written byte is a special frame |
| irq_req_chg | output | 1 | Loopback-change interrupt pulse |
| irq_listen | output | 1 | Listen interrupt pulse |
| loop_active | output | 1 | Loopback in effect |
| dis_bits | output | 32 | Per-channel disable bits |
| fx_bits | output | 32 | Per-channel flexible control bits |
| tx_oe_n | output | 1 | Active-low outgoing enable |

## Verification
A special frame that carries a request-bit edge and a channel frame-start strobe can arrive in the same cycle. In that case the new pending flag must not be applied by that strobe, while an older pending flag is applied. The bench forces this collision in directed steps, once for activation and once for deactivation. It then produces it often under random stimulus, by raising the strobe rate and by changing the request bit on most special frames. The outcome is judged on `loop_active` and on the capture strobes, checked every cycle against a cycle model built from the requirements.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

    localparam int unsigned CCL_NCH_DEF  = 32;
    localparam int unsigned CCL_REQ_BIT  = 0;
    localparam int unsigned CCL_DIS_BIT  = 4;

    typedef struct packed {
        logic loop;
        logic prev;
        logic pend_on;
        logic pend_off;
    } ccl_loop_t;

    typedef struct packed {
        logic       we;
        logic [7:0] wdata;
        logic       special;
        logic       irq_chg;
        logic       irq_lst;
    } ccl_cap_t;

endpackage

// File: rtl/ccl_loop_fsm.sv
module ccl_loop_fsm
    import ccl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_en,
    input  logic sf_mode,
    input  logic sw_loop,
    input  logic sf_valid,
    input  logic req_bit,
    input  logic ch_start,
    output logic loop_active,
    output logic chg_evt,
    output logic sf_capture
);

    ccl_loop_t st_d, st_q;
    logic hw_mode;
    logic rise;
    logic fall;

    always_comb begin
        hw_mode    = hw_en & sf_mode;
        rise       = hw_mode & sf_valid &  req_bit & ~st_q.prev;
        fall       = hw_mode & sf_valid & ~req_bit &  st_q.prev;
        chg_evt    = hw_en ? (rise | fall) : (sw_loop != st_q.loop);
        sf_capture = (~st_q.loop & ~st_q.pend_on) | st_q.pend_off | fall;

        st_d = st_q;
        if (sf_valid) begin
            st_d.prev = req_bit;
        end

        if (!hw_mode) begin
            st_d.pend_on  = 1'b0;
            st_d.pend_off = 1'b0;
        end else begin
            st_d.pend_on  = rise | (st_q.pend_on  & ~ch_start & ~fall);
            st_d.pend_off = fall | (st_q.pend_off & ~ch_start & ~rise);
        end

        if (!hw_en) begin
            st_d.loop = sw_loop;
        end else if (hw_mode && ch_start) begin
            if (st_q.pend_on) begin
                st_d.loop = 1'b1;
            end else if (st_q.pend_off) begin
                st_d.loop = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign loop_active = st_q.loop;

endmodule

// File: rtl/ccl_chan_bits.sv
module ccl_chan_bits #(
    parameter int unsigned NCH  = 32,
    parameter int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_W-1:0] wr_chan,
    input  logic            dis_src,
    input  logic [2:0]      fx_src,
    input  logic            freeze,
    input  logic            dis_en,
    input  logic [1:0]      fx_sel,
    output logic [NCH-1:0]  dis_vec,
    output logic [NCH-1:0]  fx_vec
);

    typedef struct packed {
        logic [NCH-1:0] dis;
        logic [NCH-1:0] fx;
    } bits_t;

    bits_t          bits_d, bits_q;
    logic [NCH-1:0] dis_nx;
    logic [NCH-1:0] fx_nx;
    logic           upd;
    logic           new_dis;
    logic           new_fx;

    always_comb begin
        upd     = wr_en & ~freeze;
        new_dis = dis_en & dis_src;
        case (fx_sel)
            2'b11:   new_fx = fx_src[2];
            2'b10:   new_fx = fx_src[1];
            2'b01:   new_fx = fx_src[0];
            default: new_fx = 1'b0;
        endcase
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign dis_nx[g] = (upd && (wr_chan == CH_W'(g))) ? new_dis : bits_q.dis[g];
        assign fx_nx[g]  = (upd && (wr_chan == CH_W'(g))) ? new_fx  : bits_q.fx[g];
    end

    always_comb begin
        bits_d.dis = dis_nx;
        bits_d.fx  = fx_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign dis_vec = bits_q.dis;
    assign fx_vec  = bits_q.fx;

endmodule

// File: rtl/ccl_oe_gen.sv
module ccl_oe_gen #(
    parameter int unsigned NCH  = 32,
    parameter int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ch_start,
    input  logic [CH_W-1:0] ch_idx,
    input  logic            long_tail,
    output logic            oe_n
);

    localparam logic [CH_W:0] LIM_SHORT = (CH_W+1)'(NCH);
    localparam logic [CH_W:0] LIM_LONG  = (CH_W+1)'(NCH / 2);

    logic          oe_n_d, oe_n_q;
    logic [CH_W:0] limit;

    always_comb begin
        limit  = long_tail ? LIM_LONG : LIM_SHORT;
        oe_n_d = oe_n_q;
        if (ch_start) begin
            oe_n_d = ~({1'b0, ch_idx} < limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_n_q <= 1'b1;
        end else begin
            oe_n_q <= oe_n_d;
        end
    end

    assign oe_n = oe_n_q;

endmodule

// File: rtl/ccl_reflect_ctrl.sv
module ccl_reflect_ctrl
    import ccl_pkg::*;
#(
    parameter int unsigned NCH  = CCL_NCH_DEF,
    parameter int unsigned CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_hw_en,
    input  logic            cfg_sf_mode,
    input  logic            cfg_sw_loop,
    input  logic            cfg_listen,
    input  logic            cfg_dis_en,
    input  logic [1:0]      cfg_fx_sel,
    input  logic            cfg_long_tail,
    input  logic            cfg_chg_mask,
    input  logic            ch_start,
    input  logic [CH_W-1:0] ch_idx,
    input  logic            rx_valid,
    input  logic            rx_special,
    input  logic [CH_W-1:0] rx_chan,
    input  logic [7:0]      rx_byte,
    output logic            ram_we,
    output logic [7:0]      ram_wdata,
    output logic            ram_special,
    output logic            irq_req_chg,
    output logic            irq_listen,
    output logic            loop_active,
    output logic [NCH-1:0]  dis_bits,
    output logic [NCH-1:0]  fx_bits,
    output logic            tx_oe_n
);

    ccl_cap_t cap_d, cap_q;
    logic     sf_valid;
    logic     data_valid;
    logic     chg_evt;
    logic     sf_capture;

    assign sf_valid   = rx_valid &  rx_special;
    assign data_valid = rx_valid & ~rx_special;

    ccl_loop_fsm u_loop (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_en       (cfg_hw_en),
        .sf_mode     (cfg_sf_mode),
        .sw_loop     (cfg_sw_loop),
        .sf_valid    (sf_valid),
        .req_bit     (rx_byte[CCL_REQ_BIT]),
        .ch_start    (ch_start),
        .loop_active (loop_active),
        .chg_evt     (chg_evt),
        .sf_capture  (sf_capture)
    );

    ccl_chan_bits #(.NCH(NCH), .CH_W(CH_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (data_valid),
        .wr_chan (rx_chan),
        .dis_src (rx_byte[CCL_DIS_BIT]),
        .fx_src  (rx_byte[2:0]),
        .freeze  (loop_active),
        .dis_en  (cfg_dis_en),
        .fx_sel  (cfg_fx_sel),
        .dis_vec (dis_bits),
        .fx_vec  (fx_bits)
    );

    ccl_oe_gen #(.NCH(NCH), .CH_W(CH_W)) u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_start  (ch_start),
        .ch_idx    (ch_idx),
        .long_tail (cfg_long_tail),
        .oe_n      (tx_oe_n)
    );

    always_comb begin
        cap_d.we      = (sf_valid & sf_capture) |
                        (data_valid & (~loop_active | cfg_listen));
        cap_d.wdata   = rx_byte;
        cap_d.special = sf_valid;
        cap_d.irq_chg = chg_evt & ~cfg_chg_mask;
        cap_d.irq_lst = data_valid & loop_active & cfg_listen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign ram_we      = cap_q.we;
    assign ram_wdata   = cap_q.wdata;
    assign ram_special = cap_q.special;
    assign irq_req_chg = cap_q.irq_chg;
    assign irq_listen  = cap_q.irq_lst;

endmodule

// File: rtl/ccl_reflect_chk.sv
module ccl_reflect_chk #(
    parameter int unsigned NCH = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_hw_en,
    input logic           cfg_chg_mask,
    input logic           ch_start,
    input logic           ram_we,
    input logic           ram_special,
    input logic           irq_req_chg,
    input logic           irq_listen,
    input logic           loop_active,
    input logic [NCH-1:0] dis_bits,
    input logic [NCH-1:0] fx_bits,
    input logic           tx_oe_n
);

    // R1
    hw_switch_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(loop_active) && $past(cfg_hw_en) && cfg_hw_en) |-> $past(ch_start));

    // R4
    chg_irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg_mask |=> !irq_req_chg);

    // R6
    freeze_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |=> ($stable(dis_bits) && $stable(fx_bits)));

    // R9
    listen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_listen |-> (ram_we && !ram_special));

    // R10
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_start |=> $stable(tx_oe_n));

endmodule

bind ccl_reflect_ctrl ccl_reflect_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_hw_en    (cfg_hw_en),
    .cfg_chg_mask (cfg_chg_mask),
    .ch_start     (ch_start),
    .ram_we       (ram_we),
    .ram_special  (ram_special),
    .irq_req_chg  (irq_req_chg),
    .irq_listen   (irq_listen),
    .loop_active  (loop_active),
    .dis_bits     (dis_bits),
    .fx_bits      (fx_bits),
    .tx_oe_n      (tx_oe_n)
);

// File: tb/ccl_reflect_ctrl_tb.sv
`timescale 1ns/1ps
module ccl_reflect_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_hw_en = 1'b0, cfg_sf_mode = 1'b0, cfg_sw_loop = 1'b0;
    logic        cfg_listen = 1'b0, cfg_dis_en = 1'b0, cfg_long_tail = 1'b0;
    logic        cfg_chg_mask = 1'b0;
    logic [1:0]  cfg_fx_sel = 2'b00;
    logic        ch_start = 1'b0, rx_valid = 1'b0, rx_special = 1'b0;
    logic [4:0]  ch_idx = '0, rx_chan = '0;
    logic [7:0]  rx_byte = '0;
    logic        ram_we, ram_special, irq_req_chg, irq_listen, loop_active, tx_oe_n;
    logic [7:0]  ram_wdata;
    logic [31:0] dis_bits, fx_bits;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model state
    logic        m_loop, m_prev, m_pon, m_poff, m_oe_n;
    logic        m_we, m_sp, m_irqc, m_irql;
    logic [7:0]  m_wd;
    logic [31:0] m_dis, m_fx;

    always #5 clk = ~clk;

    ccl_reflect_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_hw_en(cfg_hw_en), .cfg_sf_mode(cfg_sf_mode), .cfg_sw_loop(cfg_sw_loop),
        .cfg_listen(cfg_listen), .cfg_dis_en(cfg_dis_en), .cfg_fx_sel(cfg_fx_sel),
        .cfg_long_tail(cfg_long_tail), .cfg_chg_mask(cfg_chg_mask),
        .ch_start(ch_start), .ch_idx(ch_idx),
        .rx_valid(rx_valid), .rx_special(rx_special), .rx_chan(rx_chan), .rx_byte(rx_byte),
        .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_special(ram_special),
        .irq_req_chg(irq_req_chg), .irq_listen(irq_listen), .loop_active(loop_active),
        .dis_bits(dis_bits), .fx_bits(fx_bits), .tx_oe_n(tx_oe_n)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic fx_pick(input logic [1:0] sel, input logic [7:0] b);
        case (sel)
            2'b11:   return b[2];
            2'b10:   return b[1];
            2'b01:   return b[0];
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_reset();
        m_loop = 0; m_prev = 0; m_pon = 0; m_poff = 0; m_oe_n = 1;
        m_we = 0; m_sp = 0; m_irqc = 0; m_irql = 0; m_wd = '0;
        m_dis = '0; m_fx = '0;
    endtask

    // next state from the requirements, using the inputs driven for this cycle
    task automatic model_step();
        logic hwm, sf, dv, rise, fall, n_loop, n_pon, n_poff;
        hwm  = cfg_hw_en & cfg_sf_mode;
        sf   = rx_valid & rx_special;
        dv   = rx_valid & ~rx_special;
        rise = hwm & sf &  rx_byte[0] & ~m_prev;
        fall = hwm & sf & ~rx_byte[0] &  m_prev;
        m_irqc = ~cfg_chg_mask & (cfg_hw_en ? (rise | fall) : (cfg_sw_loop != m_loop));
        m_we   = (sf & ((~m_loop & ~m_pon) | m_poff | fall)) | (dv & (~m_loop | cfg_listen));
        m_sp   = sf;
        m_wd   = rx_byte;
        m_irql = dv & m_loop & cfg_listen;
        if (dv && !m_loop) begin
            m_dis[rx_chan] = cfg_dis_en & rx_byte[4];
            m_fx[rx_chan]  = fx_pick(cfg_fx_sel, rx_byte);
        end
        n_loop = m_loop;
        if (!cfg_hw_en) n_loop = cfg_sw_loop;
        else if (hwm && ch_start) begin
            if (m_pon) n_loop = 1'b1;
            else if (m_poff) n_loop = 1'b0;
        end
        n_pon  = hwm & (rise | (m_pon  & ~ch_start & ~fall));
        n_poff = hwm & (fall | (m_poff & ~ch_start & ~rise));
        if (ch_start) m_oe_n = ~(ch_idx < (cfg_long_tail ? 5'd16 : 6'd32));
        if (sf) m_prev = rx_byte[0];
        m_loop = n_loop; m_pon = n_pon; m_poff = n_poff;
    endtask

    task automatic check_all();
        chk("R1/R2/R5", "loop_active", 32'(loop_active), 32'(m_loop));
        chk("R3/R9", "ram_we", 32'(ram_we), 32'(m_we));
        if (m_we) begin
            chk("R3/R9", "ram_wdata", 32'(ram_wdata), 32'(m_wd));
            chk("R3", "ram_special", 32'(ram_special), 32'(m_sp));
        end
        chk("R4", "irq_req_chg", 32'(irq_req_chg), 32'(m_irqc));
        chk("R9", "irq_listen", 32'(irq_listen), 32'(m_irql));
        chk("R6/R8", "dis_bits", dis_bits, m_dis);
        chk("R6/R7", "fx_bits", fx_bits, m_fx);
        chk("R10", "tx_oe_n", 32'(tx_oe_n), 32'(m_oe_n));
    endtask

    // inputs are set just after a falling edge; this advances one clock
    task automatic step();
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        ch_start = 0; rx_valid = 0; rx_special = 0;
    endtask

    task automatic send_sf(input logic req, input logic strobe);
        idle();
        rx_valid = 1; rx_special = 1; rx_byte = {7'h2a, req};
        ch_start = strobe; ch_idx = 5'd3;
        step();
    endtask

    task automatic strobe(input logic [4:0] ch);
        idle();
        ch_start = 1; ch_idx = ch;
        step();
    endtask

    task automatic send_data(input logic [4:0] ch, input logic [7:0] b);
        idle();
        rx_valid = 1; rx_special = 0; rx_chan = ch; rx_byte = b;
        step();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "loop_active", 32'(loop_active), 0);
        chk("R11", "ram_we", 32'(ram_we), 0);
        chk("R11", "irq_req_chg", 32'(irq_req_chg), 0);
        chk("R11", "tx_oe_n", 32'(tx_oe_n), 1);
        chk("R11", "dis_bits", dis_bits, 0);
        rst_n = 1;

        cfg_hw_en = 1; cfg_sf_mode = 1; cfg_dis_en = 1; cfg_fx_sel = 2'b11;
        step();
        send_data(5'd7, 8'h14);            // R7/R8: dis=1 fx=1 on channel 7
        chk("R8", "dis ch7", 32'(dis_bits[7]), 1);
        chk("R7", "fx ch7", 32'(fx_bits[7]), 1);
        // R11/R1: first frame with bit 1 is a rise; same-cycle strobe does not apply it
        send_sf(1'b1, 1'b1);
        chk("R3", "rise frame written", 32'(ram_we), 1);
        chk("R4", "rise irq", 32'(irq_req_chg), 1);
        chk("R1", "no switch on same strobe", 32'(loop_active), 0);
        send_sf(1'b1, 1'b0);
        chk("R3", "frame after rise not written", 32'(ram_we), 0);
        strobe(5'd20);
        chk("R1", "on after next strobe", 32'(loop_active), 1);
        chk("R10", "oe ch20 short", 32'(tx_oe_n), 0);
        send_data(5'd7, 8'h00);
        chk("R6", "dis frozen", 32'(dis_bits[7]), 1);
        chk("R9", "listen off: no write", 32'(ram_we), 0);
        cfg_listen = 1;
        send_data(5'd7, 8'h00);
        chk("R9", "listen irq", 32'(irq_listen), 1);
        // R2: fall together with a strobe, deactivation waits
        send_sf(1'b0, 1'b1);
        chk("R3", "fall frame written", 32'(ram_we), 1);
        chk("R2", "still on", 32'(loop_active), 1);
        strobe(5'd20);
        chk("R2", "off after strobe", 32'(loop_active), 0);
        cfg_long_tail = 1;
        strobe(5'd20);
        chk("R10", "oe ch20 long", 32'(tx_oe_n), 1);
        cfg_chg_mask = 1;
        send_sf(1'b1, 1'b0);
        chk("R4", "masked irq", 32'(irq_req_chg), 0);
        cfg_chg_mask = 0;
        // R5 software control
        cfg_hw_en = 0; cfg_sw_loop = 1; idle(); step();
        chk("R5", "sw on", 32'(loop_active), 1);
        send_sf(1'b0, 1'b1);
        chk("R5", "req ignored", 32'(loop_active), 1);
        cfg_sw_loop = 0; idle(); step();
        chk("R5", "sw off", 32'(loop_active), 0);
        for (int s = 0; s < 4; s++) begin
            cfg_fx_sel = 2'(s);
            send_data(5'd9, 8'h05);
            chk("R7", "fx sel sweep", 32'(fx_bits[9]), 32'(fx_pick(2'(s), 8'h05)));
        end

        // random phase, fixed seed
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 4000; i++) begin
            if ((i % 500) == 0) begin
                cfg_hw_en    = ($urandom % 4) != 0;
                cfg_sf_mode  = ($urandom % 5) != 0;
                cfg_listen   = $urandom % 2;
                cfg_dis_en   = $urandom % 2;
                cfg_long_tail = $urandom % 2;
            end
            if (($urandom % 16) == 0) cfg_fx_sel = 2'($urandom);
            if (($urandom % 20) == 0) cfg_sw_loop = ~cfg_sw_loop;
            cfg_chg_mask = ($urandom % 8) == 0;
            ch_start   = ($urandom % 3) == 0;
            ch_idx     = 5'($urandom);
            rx_valid   = ($urandom % 2) == 0;
            rx_special = ($urandom % 3) == 0;
            rx_chan    = 5'($urandom);
            rx_byte    = 8'($urandom);
            if (rx_special && (($urandom % 4) != 0)) rx_byte[0] = ~m_prev;
            step();
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule